// File: doc/BRIEF.md
# Multiplexed Parallel Slave Port

This block lets a host reach an internal word memory over a 16-bit shared address/data bus. The host selects the port with an active-high chip select. It pulses an address-latch input while the word address sits on the low 14 bus lines. It then sets a direction input, high for a read and low for a write, and raises one or both byte-lane strobes. On the device side the block presents a held word address, a one-cycle read request, and a one-cycle write pulse that carries write data and two byte enables. It accepts returned read data from the memory.

Every host input crosses into the system clock through a two-stage synchronizer. A read strobe starts a fixed access window. During that window the output register shows a filler word. The memory word follows once the window ends, and a read always returns all 16 bits. Write data and lane enables are captured when the strobe rises. The write itself is issued when the strobe falls. One latched address serves any number of later strobes. An address-latch pulse that coincides with a strobe is treated as a protocol fault: the strobe is dropped and a sticky flag is raised.

Top module: `mux_slave_port`

## Requirements
- R1: After reset, bus_oe, mem_re, mem_we and err_flag are 0 and mem_addr is 0.
- R2: While the port is selected, latch_in is high and neither strobe is high, mem_addr takes bus_in[13:0]. Bits 15:14 are never part of the address, and mem_addr holds its value until the next such latch.
- R3: bus_oe is 1 exactly when the synchronized chip select, direction (high) and at least one strobe are all 1. It follows the pins two clock cycles late, so with direction low, select low, or both strobes low, the bus is released.
- R4: A strobe rise while the port is selected and direction is high produces a single-cycle mem_re, three cycles after the pin edge.
- R5: After mem_re, bus_out shows FILL_WORD for ACC_LAT cycles and then the full 16-bit memory word, whichever lanes were strobed.
- R6: For a write, bus_in and the lane enables {strobe1, strobe0} are captured at the strobe rise. mem_be bit 0 covers bits 7:0 and bit 1 covers bits 15:8. A single-cycle mem_we follows three cycles after the strobe falls.
- R7: Repeated strobes without a new latch pulse access the same held address.
- R8: Seeing latch_in together with a strobe while selected starts no access and sets err_flag. The flag stays set until err_clr is sampled high with no new fault.
- R9: With chip select low, a strobe causes neither a read nor a write, and the bus stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 16 | Shared bus as seen at the pins |
| bus_out | output | 16 | Read data toward the pins |
| bus_oe | output | 1 | Drive enable for bus_out |
| sel_in | input | 1 | Chip select, active high |
| dir_in | input | 1 | 1 = read, 0 = write |
| latch_in | input | 1 | Address latch strobe |
| stb0_in | input | 1 | Low byte lane strobe |
| stb1_in | input | 1 | High byte lane strobe |
| err_clr | input | 1 | Clears the protocol error flag |
| err_flag | output | 1 | Sticky protocol error |
| mem_addr | output | 14 | Held word address |
| mem_wdata | output | 16 | Write data |
| mem_be | output | 2 | Byte enables |
| mem_we | output | 1 | Write pulse |
| mem_re | output | 1 | Read request pulse |
| mem_rdata | input | 16 | Memory read data |

## Verification
Each result has a fixed latency. bus_oe is due two edges after a pin change. mem_re, err_flag and the address update come one edge after that. mem_we arrives three edges after the strobe falls. Valid read data appears ACC_LAT edges after mem_re. The bench keeps a history queue of the pins it drives, reads the synchronized view out of that queue at the matching depth, and compares every output at the falling clock edge on every cycle. Named checks are made only after each stimulus has been held long enough to reach steady state.

// File: rtl/mux_slave_port.sv
module mux_slave_port #(
  parameter int DW        = 16,
  parameter int AW        = 14,
  parameter int SYNC      = 2,
  parameter int ACC_LAT   = 3,
  parameter logic [15:0] FILL_WORD = 16'hD00D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic          sel_in,
  input  logic          dir_in,
  input  logic          latch_in,
  input  logic          stb0_in,
  input  logic          stb1_in,
  input  logic          err_clr,
  output logic          err_flag,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [1:0]    mem_be,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata
);
  localparam int IW = DW + 5;
  localparam int CW = $clog2(ACC_LAT + 1);

  logic [IW-1:0] sync_q [SYNC];
  logic [IW-1:0] s;
  logic          s_sel, s_dir, s_lat, s_b1, s_b0, stb, p_stb, rise, fall, go;
  logic [DW-1:0] s_bus;
  logic          wr_pend;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {sel_in, dir_in, latch_in, stb1_in, stb0_in, bus_in};
      for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign s = sync_q[SYNC-1];
  assign {s_sel, s_dir, s_lat, s_b1, s_b0, s_bus} = s;
  assign stb    = s_b0 | s_b1;
  assign rise   = stb & ~p_stb;
  assign fall   = ~stb & p_stb;
  assign go     = rise & s_sel & ~s_lat;
  assign bus_oe = s_sel & s_dir & stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_stb     <= 1'b0;
      mem_re    <= 1'b0;
      mem_we    <= 1'b0;
      wr_pend   <= 1'b0;
      mem_wdata <= '0;
      mem_be    <= '0;
      mem_addr  <= '0;
      err_flag  <= 1'b0;
      cnt       <= '0;
      bus_out   <= '0;
    end else begin
      p_stb  <= stb;
      mem_re <= go & s_dir;
      mem_we <= fall & wr_pend;
      if (fall) wr_pend <= 1'b0;
      if (go && !s_dir) begin
        wr_pend   <= 1'b1;
        mem_wdata <= s_bus;
        mem_be    <= {s_b1, s_b0};
      end
      if (s_sel && s_lat && !stb) mem_addr <= s_bus[AW-1:0];
      if (s_sel && s_lat && stb) err_flag <= 1'b1;
      else if (err_clr)          err_flag <= 1'b0;
      if (go && s_dir) begin
        cnt     <= CW'(ACC_LAT);
        bus_out <= FILL_WORD;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) bus_out <= mem_rdata;
      end
    end
  end

  a_r4_re_single: assert property (@(posedge clk) disable iff (!rst_n) mem_re |=> !mem_re);
  a_r6_we_single: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !mem_we);
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n) !(mem_we && mem_re));
  a_r5_filler: assert property (@(posedge clk) disable iff (!rst_n)
    (ACC_LAT > 1) && mem_re |=> bus_out == FILL_WORD);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !s_lat |=> $stable(mem_addr));
  a_r9_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    !s_sel |=> !mem_re);
endmodule

// File: tb/test_mux_slave_port.sv
`timescale 1ns/1ps
module test_mux_slave_port;
  localparam int LAT = 3;
  localparam logic [15:0] FILL = 16'hD00D;

  logic clk = 0, rst_n = 0;
  logic [15:0] bus_in = 0, bus_out, mem_wdata, mem_rdata;
  logic bus_oe, sel_in = 0, dir_in = 0, latch_in = 0, stb0_in = 0, stb1_in = 0;
  logic err_clr = 0, err_flag, mem_we, mem_re;
  logic [13:0] mem_addr;
  logic [1:0] mem_be;
  int checks = 0, errors = 0, re_count = 0, we_count = 0;

  always #2.5 clk = ~clk;

  mux_slave_port #(.ACC_LAT(LAT), .FILL_WORD(FILL)) i_mux_slave_port (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .sel_in(sel_in), .dir_in(dir_in), .latch_in(latch_in), .stb0_in(stb0_in),
    .stb1_in(stb1_in), .err_clr(err_clr), .err_flag(err_flag), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata));

  function automatic logic [15:0] dflt(int i);
    return 16'(i * 16'h0123) ^ 16'h5C3A;
  endfunction

  logic [15:0] bmem [64];
  logic [15:0] emem [64];
  initial for (int i = 0; i < 64; i++) begin bmem[i] = dflt(i); emem[i] = dflt(i); end
  assign mem_rdata = bmem[mem_addr[5:0]];
  always @(posedge clk) if (rst_n && mem_we) begin
    if (mem_be[0]) bmem[mem_addr[5:0]][7:0]  <= mem_wdata[7:0];
    if (mem_be[1]) bmem[mem_addr[5:0]][15:8] <= mem_wdata[15:8];
  end
  always @(posedge clk) if (rst_n) begin
    if (mem_re) re_count++;
    if (mem_we) we_count++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: pin history queue, bit 20 sel, 19 dir, 18 latch, 17 stb1, 16 stb0
  logic [20:0] hq[$];
  logic [13:0] e_addr;
  logic [15:0] e_wd, e_dout;
  logic [1:0]  e_be;
  logic e_re, e_we, e_pend, e_err;
  int e_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      hq = '{21'd0, 21'd0, 21'd0, 21'd0};
      e_addr <= 0; e_wd <= 0; e_dout <= 0; e_be <= 0;
      e_re <= 0; e_we <= 0; e_pend <= 0; e_err <= 0; e_cnt <= 0;
    end else begin
      logic [20:0] s, p;
      logic sst, pst, go;
      hq.push_front({sel_in, dir_in, latch_in, stb1_in, stb0_in, bus_in});
      void'(hq.pop_back());
      s = hq[2]; p = hq[3];
      sst = s[16] | s[17];
      pst = p[16] | p[17];
      go = sst && !pst && s[20] && !s[18];
      e_re <= go && s[19];
      e_we <= !sst && pst && e_pend;
      if (!sst && pst) begin
        e_pend <= 0;
        if (e_pend) begin
          if (e_be[0]) emem[e_addr[5:0]][7:0]  = e_wd[7:0];
          if (e_be[1]) emem[e_addr[5:0]][15:8] = e_wd[15:8];
        end
      end
      if (go && !s[19]) begin e_pend <= 1; e_wd <= s[15:0]; e_be <= s[17:16]; end
      if (s[20] && s[18] && !sst) e_addr <= s[13:0];
      if (s[20] && s[18] && sst) e_err <= 1;
      else if (err_clr) e_err <= 0;
      if (go && s[19]) begin e_cnt <= LAT; e_dout <= FILL; end
      else if (e_cnt > 0) begin
        e_cnt <= e_cnt - 1;
        if (e_cnt == 1) e_dout <= emem[e_addr[5:0]];
      end
    end
  end

  always @(negedge clk) if (rst_n && hq.size() == 4) begin
    logic [20:0] h;
    logic eoe;
    h = hq[1];
    eoe = h[20] && h[19] && (h[16] || h[17]);
    chk(bus_oe === eoe, "R3 bus_oe", 32'(bus_oe), 32'(eoe));
    chk(mem_re === e_re, "R4 mem_re", 32'(mem_re), 32'(e_re));
    chk(mem_we === e_we, "R6 mem_we", 32'(mem_we), 32'(e_we));
    chk(err_flag === e_err, "R8 err_flag", 32'(err_flag), 32'(e_err));
    chk(mem_addr === e_addr, "R2 mem_addr", 32'(mem_addr), 32'(e_addr));
    if (eoe) chk(bus_out === e_dout, "R5 bus_out", 32'(bus_out), 32'(e_dout));
    if (e_we) begin
      chk(mem_wdata === e_wd, "R6 mem_wdata", 32'(mem_wdata), 32'(e_wd));
      chk(mem_be === e_be, "R6 mem_be", 32'(mem_be), 32'(e_be));
    end
  end

  task automatic drive(input logic s, d, l, b1, b0, input logic [15:0] v, input int n);
    @(negedge clk);
    sel_in = s; dir_in = d; latch_in = l; stb1_in = b1; stb0_in = b0; bus_in = v;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic latch_addr(input logic [15:0] v);
    drive(1, 0, 1, 0, 0, v, 3);
    drive(1, 0, 0, 0, 0, v, 5);
  endtask

  task automatic write(input logic b1, b0, input logic [15:0] v);
    drive(1, 0, 0, b1, b0, v, 3);
    drive(1, 0, 0, 0, 0, 16'h0, 6);
  endtask

  task automatic read(input logic b1, b0, input logic [15:0] exp, input string tag);
    drive(1, 1, 0, b1, b0, 16'h0, LAT + 8);
    chk(bus_oe === 1'b1, tag, 32'(bus_oe), 32'd1);
    chk(bus_out === exp, tag, 32'(bus_out), 32'(exp));
    drive(1, 1, 0, 0, 0, 16'h0, 5);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(bus_oe === 0 && mem_re === 0 && mem_we === 0 && err_flag === 0, "R1 reset outputs",
        {bus_oe, mem_re, mem_we, err_flag}, 32'd0);
    chk(mem_addr === 0, "R1 reset address", 32'(mem_addr), 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    latch_addr(16'hF123);
    chk(mem_addr === 14'h3123, "R2 latched address", 32'(mem_addr), 32'h3123);
    write(1, 1, 16'hA55A);
    chk(we_count == 1, "R6 one write", we_count, 1);
    read(1, 1, 16'hA55A, "R5 full word read");
    write(0, 1, 16'h0011);
    read(1, 0, 16'hA511, "R7 R6 low lane write, high strobe read");
    write(1, 0, 16'h7700);
    read(0, 1, 16'h7711, "R7 R6 high lane write, low strobe read");
    chk(mem_addr === 14'h3123, "R7 address held", 32'(mem_addr), 32'h3123);

    latch_addr(16'h0005);
    read(1, 1, dflt(5), "R5 untouched word");
    chk(re_count == 4, "R4 read count", re_count, 4);

    drive(0, 1, 0, 1, 1, 16'h0, 8);
    chk(bus_oe === 0, "R9 deselected oe", 32'(bus_oe), 0);
    drive(0, 0, 0, 0, 0, 16'h0, 6);
    chk(re_count == 4 && we_count == 3, "R9 no access", re_count * 16 + we_count, 4 * 16 + 3);

    drive(1, 0, 0, 1, 1, 16'hBEEF, 6);
    chk(bus_oe === 0, "R3 write direction releases bus", 32'(bus_oe), 0);
    drive(1, 0, 0, 0, 0, 16'h0, 6);
    read(1, 1, 16'hBEEF, "R6 R3 write then read");

    drive(1, 0, 1, 0, 1, 16'h1234, 6);
    drive(1, 0, 0, 0, 0, 16'h0, 6);
    chk(err_flag === 1, "R8 flag set", 32'(err_flag), 1);
    chk(we_count == 4 && mem_addr === 14'h0005, "R8 strobe ignored",
        32'(we_count), 4);
    drive(1, 0, 0, 0, 0, 16'h0, 6);
    chk(err_flag === 1, "R8 flag sticky", 32'(err_flag), 1);
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
    repeat (3) @(negedge clk);
    chk(err_flag === 0, "R8 flag cleared", 32'(err_flag), 0);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule